// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block keeps the byte count that governs DMA bursts in a SCSI host controller. Software writes the count one byte at a time into a staging register. A command whose top bit is set copies the staged count into the working count, which software can read back. When that command is the transfer command, the block also works out how long the burst really is. A staged count of zero is read as the full 65536 bytes. The burst length is then limited either to the size of the bus phase still pending or, in command-capture mode, to 32 command bytes.

While a burst runs, the data path offers chunks of bytes. The block accepts as many bytes of each chunk as the remaining length allows. It moves a signed phase-size register toward zero by the same amount, where a negative value means data flows from host to device. When nothing remains, it sets the terminal-count flag, clears the working count and gives a one-cycle completion strobe. Any write to a count byte clears the terminal-count flag.

Top module: `dma_len_counter`

## Requirements
- R1: After a synchronous reset, every output is zero: staged count, working count, terminal count, remaining length, phase size, busy and done.
- R2: A count write with `cnt_wr_sel`=0 loads the low byte of the staged count and one with `cnt_wr_sel`=1 loads the high byte. A count write does not change `work_count`.
- R3: A command with bit 7 of `cmd_code` set copies the staged count (the value before any write in the same cycle) into `work_count` one cycle later. A command with bit 7 clear leaves `work_count` unchanged.
- R4: A write to either count byte clears `tc_flag` one cycle later, unless a completion happens in the same cycle.
- R5: Command code 0x90 (bit 7 set, low seven bits 0x10) starts a burst. It sets `remaining` to the lesser of the programmed count and the magnitude of `phase`, where a programmed count of zero means 65536. It raises `busy`, clears `tc_flag`, and takes priority over a completion in the same cycle.
- R6: When `cmd_capture` is high at the start, the burst length is the lesser of the programmed count and 32, and accepted chunks leave `phase` unchanged.
- R7: During a burst, a chunk of length L takes min(L, `remaining`) bytes. `remaining` drops by that amount, and outside capture mode `phase` moves toward zero by that amount (it increases if negative, decreases otherwise).
- R8: The burst completes when a chunk uses up `remaining`, or one cycle after a start with zero length. Any excess in a chunk is not consumed. Completion sets `tc_flag`, zeroes `work_count`, drops `busy` and pulses `done` for exactly one cycle.
- R9: `phase_load` loads `phase_val` into `phase` one cycle later. It has priority over chunk movement. Without a load or an accepted chunk, `phase` holds.
- R10: Every output is registered and reflects the inputs of the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_wr_en | input | 1 | Write one staged count byte |
| cnt_wr_sel | input | 1 | Byte select: 0 low, 1 high |
| cnt_wr_data | input | 8 | Byte value to stage |
| cmd_valid | input | 1 | Command issued this cycle |
| cmd_code | input | 8 | Command code; bit 7 marks DMA, 0x10 in bits 6:0 is transfer |
| cmd_capture | input | 1 | Command-capture mode for a starting burst |
| phase_load | input | 1 | Load the signed phase size |
| phase_val | input | 18 | Signed phase size to load |
| chunk_valid | input | 1 | Data path offers a chunk |
| chunk_len | input | 17 | Bytes in the offered chunk |
| work_count | output | 16 | Working transfer count |
| tc_flag | output | 1 | Terminal count reached |
| remaining | output | 17 | Bytes left in the current burst |
| phase | output | 18 | Signed pending phase size |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it. A zero-length burst is the one exception: its done strobe comes one edge after busy rises, so two edges after the start command. The bench drives inputs on the falling edge and runs its reference model on the rising edge from the same inputs. It then compares all six outputs on the next falling edge, so each comparison sees the state produced by exactly one edge. Directed sequences also check values at those same falling edges: staging without reload, reload, a zero count meaning 65536, clamping to the phase and to 32, consumption of an oversized chunk, and the completion pulse.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } cnt_sel_e;

  localparam logic [6:0] OP_XFER = 7'h10;
endpackage

// File: rtl/dlc_count_regs.sv
module dlc_count_regs #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W/2-1:0] wr_data,
  input  logic             reload,
  input  logic             start,
  input  logic             complete,
  output logic [CNT_W-1:0] stage,
  output logic [CNT_W-1:0] work,
  output logic             tc
);
  localparam int HALF_W = CNT_W / 2;
  localparam int LANES  = 2;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)
        stage[g*HALF_W +: HALF_W] <= '0;
      else if (wr_en && (wr_sel == g[0]))
        stage[g*HALF_W +: HALF_W] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      work <= '0;
    else if (complete)
      work <= '0;
    else if (reload)
      work <= stage;
  end

  always_ff @(posedge clk) begin
    if (rst)
      tc <= 1'b0;
    else if (complete)
      tc <= 1'b1;
    else if (wr_en || start)
      tc <= 1'b0;
  end
endmodule

// File: rtl/dlc_len_calc.sv
module dlc_len_calc #(
  parameter int CNT_W   = 16,
  parameter int CAP_LEN = 32
) (
  input  logic [CNT_W-1:0]        stage,
  input  logic signed [CNT_W+1:0] phase,
  input  logic                    capture,
  output logic [CNT_W:0]          burst
);
  localparam int LEN_W = CNT_W + 1;
  localparam int PH_W  = CNT_W + 2;
  localparam logic [LEN_W-1:0] FULL = LEN_W'(1) << CNT_W;
  localparam logic [LEN_W-1:0] CAP  = LEN_W'(CAP_LEN);

  logic [LEN_W-1:0] prog;
  logic [PH_W-1:0]  mag;
  logic [PH_W-1:0]  prog_x;

  always_comb begin
    prog   = (stage == '0) ? FULL : {1'b0, stage};
    mag    = phase[PH_W-1] ? PH_W'(-phase) : PH_W'(phase);
    prog_x = {1'b0, prog};
    if (capture)
      burst = (prog < CAP) ? prog : CAP;
    else if (mag < prog_x)
      burst = mag[LEN_W-1:0];
    else
      burst = prog;
  end
endmodule

// File: rtl/dlc_burst_engine.sv
module dlc_burst_engine #(
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [CNT_W:0]          burst,
  input  logic                    capture,
  input  logic                    phase_load,
  input  logic signed [CNT_W+1:0] phase_val,
  input  logic                    chunk_valid,
  input  logic [CNT_W:0]          chunk_len,
  output logic                    complete,
  output logic [CNT_W:0]          remaining,
  output logic signed [CNT_W+1:0] phase,
  output logic                    active,
  output logic                    done
);
  localparam int LEN_W = CNT_W + 1;
  localparam int PH_W  = CNT_W + 2;

  logic             cap_q;
  logic [LEN_W-1:0] take;
  logic             accept;
  logic signed [PH_W-1:0] take_s;

  always_comb begin
    take     = (chunk_len < remaining) ? chunk_len : remaining;
    take_s   = $signed({1'b0, take});
    accept   = active && !start && chunk_valid;
    complete = active && !start &&
               ((remaining == '0) || (chunk_valid && (chunk_len >= remaining)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      remaining <= '0;
      active    <= 1'b0;
      cap_q     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= complete;
      if (start) begin
        remaining <= burst;
        active    <= 1'b1;
        cap_q     <= capture;
      end else if (accept) begin
        remaining <= remaining - take;
        if (complete) active <= 1'b0;
      end else if (complete) begin
        active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (phase_load)
      phase <= phase_val;
    else if (accept && !cap_q) begin
      if (phase < 0)
        phase <= phase + take_s;
      else
        phase <= phase - take_s;
    end
  end
endmodule

// File: rtl/dma_len_counter.sv
module dma_len_counter #(
  parameter int CNT_W   = 16,
  parameter int CAP_LEN = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cnt_wr_en,
  input  logic                    cnt_wr_sel,
  input  logic [CNT_W/2-1:0]      cnt_wr_data,
  input  logic                    cmd_valid,
  input  logic [7:0]              cmd_code,
  input  logic                    cmd_capture,
  input  logic                    phase_load,
  input  logic signed [CNT_W+1:0] phase_val,
  input  logic                    chunk_valid,
  input  logic [CNT_W:0]          chunk_len,
  output logic [CNT_W-1:0]        work_count,
  output logic                    tc_flag,
  output logic [CNT_W:0]          remaining,
  output logic signed [CNT_W+1:0] phase,
  output logic                    busy,
  output logic                    done
);
  import dlc_pkg::*;

  logic             reload;
  logic             start;
  logic             complete;
  logic [CNT_W-1:0] stage;
  logic [CNT_W:0]   burst;

  assign reload = cmd_valid && cmd_code[7];
  assign start  = reload && (cmd_code[6:0] == OP_XFER);

  dlc_count_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cnt_wr_en),
    .wr_sel   (cnt_wr_sel),
    .wr_data  (cnt_wr_data),
    .reload   (reload),
    .start    (start),
    .complete (complete),
    .stage    (stage),
    .work     (work_count),
    .tc       (tc_flag)
  );

  dlc_len_calc #(.CNT_W(CNT_W), .CAP_LEN(CAP_LEN)) u_len (
    .stage   (stage),
    .phase   (phase),
    .capture (cmd_capture),
    .burst   (burst)
  );

  dlc_burst_engine #(.CNT_W(CNT_W)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .burst       (burst),
    .capture     (cmd_capture),
    .phase_load  (phase_load),
    .phase_val   (phase_val),
    .chunk_valid (chunk_valid),
    .chunk_len   (chunk_len),
    .complete    (complete),
    .remaining   (remaining),
    .phase       (phase),
    .active      (busy),
    .done        (done)
  );
endmodule

// File: rtl/dma_len_counter_chk.sv
module dma_len_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cnt_wr_en,
  input logic                    cmd_valid,
  input logic [7:0]              cmd_code,
  input logic                    phase_load,
  input logic                    chunk_valid,
  input logic [CNT_W-1:0]        work_count,
  input logic                    tc_flag,
  input logic [CNT_W:0]          remaining,
  input logic signed [CNT_W+1:0] phase,
  input logic                    busy,
  input logic                    done
);
  logic start_c;
  assign start_c = cmd_valid && cmd_code[7] && (cmd_code[6:0] == 7'h10);

  assert_wr_clears_tc_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_wr_en |=> (!tc_flag || done));

  assert_done_state_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (tc_flag && (work_count == '0) && !busy));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_start_R5: assert property (@(posedge clk) disable iff (rst)
    start_c |=> (busy && !tc_flag && !done));

  assert_no_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_code[7] && !busy) |=> $stable(work_count));

  assert_rem_shrinks_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_c) |=> (remaining <= $past(remaining)));

  assert_phase_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!phase_load && !chunk_valid) |=> $stable(phase));
endmodule

bind dma_len_counter dma_len_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cnt_wr_en   (cnt_wr_en),
  .cmd_valid   (cmd_valid),
  .cmd_code    (cmd_code),
  .phase_load  (phase_load),
  .chunk_valid (chunk_valid),
  .work_count  (work_count),
  .tc_flag     (tc_flag),
  .remaining   (remaining),
  .phase       (phase),
  .busy        (busy),
  .done        (done)
);

// File: tb/test_dma_len_counter.sv
module test_dma_len_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cnt_wr_en = 1'b0, cnt_wr_sel = 1'b0;
  logic [7:0] cnt_wr_data = '0;
  logic cmd_valid = 1'b0, cmd_capture = 1'b0;
  logic [7:0] cmd_code = '0;
  logic phase_load = 1'b0;
  logic signed [CNT_W+1:0] phase_val = '0;
  logic chunk_valid = 1'b0;
  logic [CNT_W:0] chunk_len = '0;
  logic [CNT_W-1:0] work_count;
  logic tc_flag, busy, done;
  logic [CNT_W:0] remaining;
  logic signed [CNT_W+1:0] phase;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int m_stg, m_work, m_tc, m_rem, m_ph, m_act, m_cap, m_done;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_len_counter i_dma_len_counter (.*);

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int imin(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // Reference model, behavioural, updated on each rising edge.
  always @(posedge clk) begin
    int prog, take, old_stg;
    bit compl, rel, st;
    if (rst) begin
      m_stg = 0; m_work = 0; m_tc = 0; m_rem = 0; m_ph = 0;
      m_act = 0; m_cap = 0; m_done = 0;
    end else begin
      old_stg = m_stg;
      rel = cmd_valid && cmd_code[7];
      st  = rel && (cmd_code[6:0] == 7'h10);
      compl = 0;
      take = 0;
      if (st) begin
        prog = (old_stg == 0) ? 65536 : old_stg;
        m_rem = cmd_capture ? imin(prog, 32) : imin(prog, (m_ph < 0) ? -m_ph : m_ph);
        m_act = 1;
        m_cap = cmd_capture;
      end else if (m_act) begin
        if (m_rem == 0) compl = 1;
        else if (chunk_valid) begin
          take = imin(m_rem, int'(chunk_len));
          m_rem -= take;
          if (m_rem == 0) compl = 1;
        end
      end
      if (phase_load) m_ph = int'(phase_val);
      else if (take > 0 && !m_cap) m_ph = (m_ph < 0) ? m_ph + take : m_ph - take;
      if (compl) begin
        m_act = 0; m_tc = 1; m_work = 0;
      end else begin
        if (rel) m_work = old_stg;
        if (cnt_wr_en || st) m_tc = 0;
      end
      m_done = compl;
      if (cnt_wr_en) begin
        if (cnt_wr_sel) m_stg = (m_stg & 255) | (int'(cnt_wr_data) << 8);
        else m_stg = (m_stg & 65280) | int'(cnt_wr_data);
      end
    end
  end

  // Compare every output on every falling edge (R10).
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk("R3", "work_count", work_count, m_work);
      chk("R4", "tc_flag", tc_flag, m_tc);
      chk("R7", "remaining", remaining, m_rem);
      chk("R9", "phase", phase, m_ph);
      chk("R5", "busy", busy, m_act);
      chk("R8", "done", done, m_done);
    end
  end

  task automatic wr(bit sel, logic [7:0] d);
    cnt_wr_en = 1; cnt_wr_sel = sel; cnt_wr_data = d;
    @(negedge clk); cnt_wr_en = 0;
  endtask
  task automatic cmd(logic [7:0] c, bit cap);
    cmd_valid = 1; cmd_code = c; cmd_capture = cap;
    @(negedge clk); cmd_valid = 0; cmd_capture = 0;
  endtask
  task automatic ld(int v);
    phase_load = 1; phase_val = (CNT_W+2)'(v);
    @(negedge clk); phase_load = 0;
  endtask
  task automatic chunk(int l);
    chunk_valid = 1; chunk_len = (CNT_W+1)'(l);
    @(negedge clk); chunk_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "reset work", work_count, 0);
    chk("R1", "reset tc", tc_flag, 0);
    chk("R1", "reset remaining", remaining, 0);
    chk("R1", "reset busy", busy, 0);
    // R2 staging does not touch working count
    wr(0, 8'h34); wr(1, 8'h12);
    chk("R2", "staged not reloaded", work_count, 0);
    cmd(8'h80, 0);
    chk("R3", "reload", work_count, 16'h1234);
    wr(0, 8'h00); cmd(8'h00, 0);
    chk("R3", "non-dma no reload", work_count, 16'h1234);
    // R5 clamp to phase, R7 chunks
    wr(0, 8'h40); wr(1, 8'h00); ld(100);
    chk("R9", "phase load", phase, 100);
    cmd(8'h90, 0);
    chk("R5", "burst clamp count", remaining, 64);
    chk("R5", "busy", busy, 1);
    chunk(20);
    chk("R7", "remaining after chunk", remaining, 44);
    chk("R7", "phase after chunk", phase, 80);
    chunk(50);
    chk("R8", "done pulse", done, 1);
    chk("R8", "tc set", tc_flag, 1);
    chk("R8", "work zero", work_count, 0);
    chk("R7", "oversized chunk phase", phase, 36);
    @(negedge clk);
    chk("R8", "done one cycle", done, 0);
    wr(0, 8'h00);
    chk("R4", "write clears tc", tc_flag, 0);
    // R5 zero count means 65536, host-to-device phase
    ld(-300); cmd(8'h90, 0);
    chk("R5", "zero count clamp to phase", remaining, 300);
    chunk(100);
    chk("R7", "negative phase moves up", phase, -200);
    chunk(250);
    chk("R8", "completion", done, 1);
    chk("R7", "phase at zero", phase, 0);
    ld(-100000); cmd(8'h90, 0);
    chk("R5", "zero count is 65536", remaining, 65536);
    // R6 capture mode
    wr(0, 8'd100); ld(500); cmd(8'h90, 1);
    chk("R6", "capture clamp 32", remaining, 32);
    chunk(40);
    chk("R6", "capture phase unchanged", phase, 500);
    chk("R8", "capture done", done, 1);
    // R8 zero-length burst
    ld(0); cmd(8'h90, 0);
    chk("R8", "zero burst busy", busy, 1);
    @(negedge clk);
    chk("R8", "zero burst done", done, 1);
    // Mixed traffic, compared each cycle against the model
    for (int i = 0; i < 4000; i++) begin
      cnt_wr_en   = ($urandom_range(0, 7) == 0);
      cnt_wr_sel  = $urandom_range(0, 1);
      cnt_wr_data = ($urandom_range(0, 3) == 0) ? 8'h00 : 8'($urandom_range(0, 255));
      cmd_valid   = ($urandom_range(0, 11) == 0);
      case ($urandom_range(0, 3))
        0: cmd_code = 8'h90;
        1: cmd_code = 8'h80;
        2: cmd_code = 8'h10;
        default: cmd_code = 8'($urandom_range(0, 255));
      endcase
      cmd_capture = ($urandom_range(0, 3) == 0);
      phase_load  = ($urandom_range(0, 15) == 0);
      phase_val   = (CNT_W+2)'(int'($urandom_range(0, 140000)) - 70000);
      chunk_valid = ($urandom_range(0, 1) == 1);
      chunk_len   = (CNT_W+1)'($urandom_range(0, 700));
      @(negedge clk);
    end
    cnt_wr_en = 0; cmd_valid = 0; phase_load = 0; chunk_valid = 0;
    @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule